// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block is a two-channel direct memory access engine that sits beside a CPU on one shared data bus. On each accepted request it asks the CPU for the bus, performs exactly one read from the channel's source address and one write to its destination address, and hands the bus back. One transfer moves a byte or a 16-bit word. The bus is taken for only that read/write pair, so the CPU loses a few cycles per request and never a whole block.

Each channel has a 20-bit source pointer, a 20-bit destination pointer and a 16-bit transfer counter with a reload value, plus a control register and a request-select register. A request comes either from software, through a request bit in the select register, or from a rising edge on one peripheral interrupt line chosen by that register. Interrupt masking plays no part, and the block never touches any interrupt flag. Requests that arrive while one is already waiting or being served collapse into a single pending flag.

Software writes the configuration through a one-word write port. A write chooses the channel with `cfg_ch` and the register with `cfg_reg`:
- code 0: source pointer.
- code 1: destination pointer.
- code 2: counter.
- code 3: control.
- code 4: select.

Top module: `cyc_dma`

## Requirements
- R1: After reset, `bus_req`, `m_rd`, `m_wr`, `ch_en` and `done` are all 0.
- R2: A software request moves one unit from source to destination on an enabled channel. Software raises it by writing the select register (code 4) with bit 7 set. The transfer is one read followed in the next cycle by one write. In byte mode (control bit 1 = 0) only the destination byte is written, and the byte above it is left unchanged.
- R3: In word mode (control bit 1 = 1) the two bytes at the source address, taken low byte first, are written to the destination address and the byte above it.
- R4: When a channel's enable bit (control bit 0) is 0, requests to it are ignored. No bus request is raised and no write occurs. A request ignored in this way is not remembered when the channel is enabled later.
- R5: A rising edge on interrupt line k requests a transfer when the channel's select bits [2:0] equal k. Edges on other lines do nothing. A line held high gives only one request.
- R6: With source increment (control bit 2) or destination increment (control bit 3) set, that pointer advances by 1 after a byte transfer and by 2 after a word transfer. With the bit clear, the pointer stays fixed.
- R7: The counter is loaded by writing code 2 and decrements once per transfer. On the transfer that brings it to zero in single mode (control bit 4 = 0), the channel clears its enable bit (visible on `ch_en`) and pulses `done` for exactly one cycle, and the pulse follows a bus write.
- R8: In repeat mode (control bit 4 = 1), the transfer that brings the counter to zero pulses `done`. The counter and both pointers then return to their last written values, and the channel stays enabled.
- R9: Requests that arrive while a transfer on the same channel is waiting or in progress merge into one pending request. Any number of them produces exactly one further transfer.
- R10: When both channels have a request pending in the same cycle, channel 0 performs its complete read and write first, and then channel 1 does.
- R11: `bus_req` stays high from the request through the read and the write. No read starts until `bus_gnt` has been seen high with `bus_req`, and read and write strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_reg | input | 3 | Register code (0 source, 1 destination, 2 counter, 3 control, 4 select) |
| cfg_wdata | input | 20 | Write data |
| irq_in | input | 8 | Peripheral interrupt-request lines |
| bus_req | output | 1 | Bus request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| m_rd | output | 1 | Read strobe; data is taken from `m_rdata` in the same cycle |
| m_wr | output | 1 | Write strobe |
| m_word | output | 1 | 1 for a 16-bit access, 0 for a byte |
| m_addr | output | 20 | Byte address of the access |
| m_wdata | output | 16 | Write data, byte in bits [7:0] |
| m_rdata | input | 16 | Read data, low byte at the addressed location |
| ch_en | output | 2 | Enable bit of each channel |
| done | output | 2 | One-cycle terminal-count pulse per channel |

## Verification
Two things can fall in the same cycle: channel 0 and channel 1 both setting their pending flags, and a new request landing while its channel is waiting for the grant. The first case is provoked by pointing both channels at the same interrupt line and pulsing it once. The bench judges it from the order of addresses in its access log, which must be read 0, write 0, read 1, write 1. The second case is provoked by holding the grant low, issuing further software requests while the first transfer is stalled, and then releasing the grant. The bench requires exactly two writes to come out.

// File: rtl/cyc_dma_pkg.sv
package cyc_dma_pkg;
    typedef enum logic [1:0] {ENG_IDLE, ENG_REQ, ENG_RD, ENG_WR} eng_state_t;

    localparam logic [2:0] REG_SRC = 3'd0;
    localparam logic [2:0] REG_DST = 3'd1;
    localparam logic [2:0] REG_CNT = 3'd2;
    localparam logic [2:0] REG_CTL = 3'd3;
    localparam logic [2:0] REG_SEL = 3'd4;

    localparam int CTL_EN   = 0;
    localparam int CTL_WORD = 1;
    localparam int CTL_SINC = 2;
    localparam int CTL_DINC = 3;
    localparam int CTL_RPT  = 4;
    localparam int SEL_REQ  = 7;
endpackage

// File: rtl/cyc_dma_chan.sv
module cyc_dma_chan
    import cyc_dma_pkg::*;
#(
    parameter int AW   = 20,
    parameter int CW   = 16,
    parameter int NIRQ = 8,
    localparam int SW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [AW-1:0]   wr_data,
    input  logic [NIRQ-1:0] irq_rise,
    input  logic            take,
    input  logic            fin,
    output logic            pend,
    output logic            en,
    output logic            word,
    output logic [AW-1:0]   src_addr,
    output logic [AW-1:0]   dst_addr,
    output logic            done
);
    typedef struct packed {
        logic [AW-1:0] src_base;
        logic [AW-1:0] dst_base;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] reload;
        logic [CW-1:0] cnt;
        logic          en;
        logic          word;
        logic          sinc;
        logic          dinc;
        logic          rpt;
        logic [SW-1:0] srcsel;
        logic          pend;
        logic          done;
    } chan_t;

    chan_t q, d;
    logic  req;
    logic [AW-1:0] step;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        req    = (wr_en && wr_sel == REG_SEL && wr_data[SEL_REQ]) || irq_rise[q.srcsel];
        step   = q.word ? AW'(2) : AW'(1);

        if (take) d.pend = 1'b0;

        if (fin) begin
            if (q.sinc) d.src = q.src + step;
            if (q.dinc) d.dst = q.dst + step;
            if (q.cnt == CW'(1)) begin
                d.done = 1'b1;
                if (q.rpt) begin
                    d.cnt = q.reload;
                    d.src = q.src_base;
                    d.dst = q.dst_base;
                end else begin
                    d.en = 1'b0;
                end
            end else begin
                d.cnt = q.cnt - CW'(1);
            end
        end

        if (req && q.en) d.pend = 1'b1;

        if (wr_en) begin
            case (wr_sel)
                REG_SRC: begin d.src_base = wr_data; d.src = wr_data; end
                REG_DST: begin d.dst_base = wr_data; d.dst = wr_data; end
                REG_CNT: begin d.reload = wr_data[CW-1:0]; d.cnt = wr_data[CW-1:0]; end
                REG_CTL: begin
                    d.en   = wr_data[CTL_EN];
                    d.word = wr_data[CTL_WORD];
                    d.sinc = wr_data[CTL_SINC];
                    d.dinc = wr_data[CTL_DINC];
                    d.rpt  = wr_data[CTL_RPT];
                end
                REG_SEL: d.srcsel = wr_data[SW-1:0];
                default: ;
            endcase
        end

        if (!d.en) d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend     = q.pend;
    assign en       = q.en;
    assign word     = q.word;
    assign src_addr = q.src;
    assign dst_addr = q.dst;
    assign done     = q.done;
endmodule

// File: rtl/cyc_dma_arb.sv
module cyc_dma_arb #(
    parameter int NCH  = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] pend,
    output logic           any,
    output logic [CHW-1:0] pick
);
    always_comb begin
        any  = |pend;
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) pick = CHW'(i);
        end
    end
endmodule

// File: rtl/cyc_dma_eng.sv
module cyc_dma_eng
    import cyc_dma_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int AW   = 20,
    parameter int DW   = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any,
    input  logic [CHW-1:0] pick,
    input  logic [AW-1:0]  cur_src,
    input  logic [AW-1:0]  cur_dst,
    input  logic           cur_word,
    input  logic           bus_gnt,
    input  logic [DW-1:0]  m_rdata,
    output logic [CHW-1:0] serve_ch,
    output logic           take,
    output logic           fin,
    output logic           bus_req,
    output logic           m_rd,
    output logic           m_wr,
    output logic           m_word,
    output logic [AW-1:0]  m_addr,
    output logic [DW-1:0]  m_wdata
);
    typedef struct packed {
        eng_state_t     st;
        logic [CHW-1:0] ch;
        logic [DW-1:0]  data;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d       = q;
        take    = 1'b0;
        fin     = 1'b0;
        bus_req = 1'b0;
        m_rd    = 1'b0;
        m_wr    = 1'b0;
        m_addr  = '0;
        case (q.st)
            ENG_IDLE: begin
                if (any) begin
                    take = 1'b1;
                    d.ch = pick;
                    d.st = ENG_REQ;
                end
            end
            ENG_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) d.st = ENG_RD;
            end
            ENG_RD: begin
                bus_req = 1'b1;
                m_rd    = 1'b1;
                m_addr  = cur_src;
                d.data  = cur_word ? m_rdata : DW'(m_rdata[7:0]);
                d.st    = ENG_WR;
            end
            ENG_WR: begin
                bus_req = 1'b1;
                m_wr    = 1'b1;
                m_addr  = cur_dst;
                fin     = 1'b1;
                d.st    = ENG_IDLE;
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ENG_IDLE, ch: '0, data: '0};
        else        q <= d;
    end

    assign serve_ch = q.ch;
    assign m_word   = cur_word;
    assign m_wdata  = q.data;
endmodule

// File: rtl/cyc_dma.sv
module cyc_dma
    import cyc_dma_pkg::*;
#(
    parameter int AW   = 20,
    parameter int CW   = 16,
    parameter int DW   = 16,
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_ch,
    input  logic [2:0]      cfg_reg,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic [NIRQ-1:0] irq_in,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic            m_rd,
    output logic            m_wr,
    output logic            m_word,
    output logic [AW-1:0]   m_addr,
    output logic [DW-1:0]   m_wdata,
    input  logic [DW-1:0]   m_rdata,
    output logic [1:0]      ch_en,
    output logic [1:0]      done
);
    localparam int NCH = 2;
    localparam int CHW = 1;

    logic [NIRQ-1:0] irq_q, irq_d, irq_rise;
    logic [NCH-1:0]  pend, take_v, fin_v, word_v;
    logic [AW-1:0]   src_a [NCH];
    logic [AW-1:0]   dst_a [NCH];
    logic            any, take, fin;
    logic [CHW-1:0]  pick, serve_ch;

    always_comb begin
        irq_d    = irq_in;
        irq_rise = irq_in & ~irq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign take_v[i] = take && (pick == CHW'(i));
        assign fin_v[i]  = fin && (serve_ch == CHW'(i));

        cyc_dma_chan #(.AW(AW), .CW(CW), .NIRQ(NIRQ)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_ch == CHW'(i))),
            .wr_sel   (cfg_reg),
            .wr_data  (cfg_wdata),
            .irq_rise (irq_rise),
            .take     (take_v[i]),
            .fin      (fin_v[i]),
            .pend     (pend[i]),
            .en       (ch_en[i]),
            .word     (word_v[i]),
            .src_addr (src_a[i]),
            .dst_addr (dst_a[i]),
            .done     (done[i])
        );
    end

    cyc_dma_arb #(.NCH(NCH)) u_arb (
        .pend (pend),
        .any  (any),
        .pick (pick)
    );

    cyc_dma_eng #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .any      (any),
        .pick     (pick),
        .cur_src  (src_a[serve_ch]),
        .cur_dst  (dst_a[serve_ch]),
        .cur_word (word_v[serve_ch]),
        .bus_gnt  (bus_gnt),
        .m_rdata  (m_rdata),
        .serve_ch (serve_ch),
        .take     (take),
        .fin      (fin),
        .bus_req  (bus_req),
        .m_rd     (m_rd),
        .m_wr     (m_wr),
        .m_word   (m_word),
        .m_addr   (m_addr),
        .m_wdata  (m_wdata)
    );
endmodule

// File: rtl/cyc_dma_chk.sv
module cyc_dma_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic       m_rd,
    input logic       m_wr,
    input logic [1:0] ch_en,
    input logic [1:0] done
);
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_rd && m_wr)); // R11
    AST_ACCESS_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd || m_wr) |-> bus_req); // R11
    AST_RD_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_rd) |-> $past(bus_req && bus_gnt)); // R11
    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        m_rd |=> m_wr); // R2
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        m_wr |=> (!m_wr && !m_rd)); // R11
    AST_DONE0_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done[0] |=> !done[0]); // R7
    AST_DONE1_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done[1] |=> !done[1]); // R7
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> $past(m_wr)); // R7
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == 2'b00 && !bus_req) |=> !bus_req); // R4
endmodule

bind cyc_dma cyc_dma_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .m_rd    (m_rd),
    .m_wr    (m_wr),
    .ch_en   (ch_en),
    .done    (done)
);

// File: tb/sim_cyc_dma.sv
module sim_cyc_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_ch = 1'b0;
    logic [2:0]  cfg_reg = '0;
    logic [19:0] cfg_wdata = '0;
    logic [7:0]  irq_in = '0;
    logic        bus_req, bus_gnt, m_rd, m_wr, m_word;
    logic [19:0] m_addr;
    logic [15:0] m_wdata, m_rdata;
    logic [1:0]  ch_en, done;
    logic        gnt_block = 1'b0;

    logic [7:0]  mem [0:1023];
    logic [19:0] alog [0:63];
    int          nacc = 0, nwr = 0, nreq = 0;
    int          done_cnt [2];
    int          checks = 0, errors = 0;

    localparam logic [19:0] EN = 20'h1, WORD = 20'h2, SINC = 20'h4, DINC = 20'h8, RPT = 20'h10;

    always #2 clk = ~clk;

    assign bus_gnt = bus_req & ~gnt_block;
    wire [9:0] ra  = m_addr[9:0];
    wire [9:0] ra1 = m_addr[9:0] + 10'd1;
    assign m_rdata = {mem[ra1], mem[ra]};

    cyc_dma u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg),
        .cfg_wdata(cfg_wdata), .irq_in(irq_in), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .m_rd(m_rd), .m_wr(m_wr), .m_word(m_word), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .ch_en(ch_en), .done(done)
    );

    initial begin
        done_cnt[0] = 0;
        done_cnt[1] = 0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    end

    always @(posedge clk) begin
        if (bus_req) nreq <= nreq + 1;
        if (done[0]) done_cnt[0] <= done_cnt[0] + 1;
        if (done[1]) done_cnt[1] <= done_cnt[1] + 1;
        if (m_rd || m_wr) begin
            alog[nacc % 64] <= m_addr;
            nacc <= nacc + 1;
        end
        if (m_wr) begin
            nwr <= nwr + 1;
            mem[ra] <= m_wdata[7:0];
            if (m_word) mem[ra1] <= m_wdata[15:8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic ch, input logic [2:0] r, input logic [19:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_reg = r; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input logic ch, input logic [19:0] s, input logic [19:0] dd,
                        input logic [19:0] c, input logic [19:0] ctl, input logic [19:0] sel);
        wr(ch, 3'd0, s);
        wr(ch, 3'd1, dd);
        wr(ch, 3'd2, c);
        wr(ch, 3'd4, sel);
        wr(ch, 3'd3, ctl);
    endtask

    task automatic sreq(input logic ch);
        wr(ch, 3'd4, 20'h80);
    endtask

    task automatic t_reset;
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 m_rd/m_wr", 32'({m_rd, m_wr}), 0);
        chk("R1 ch_en", 32'(ch_en), 0);
        chk("R1 done", 32'(done), 0);
    endtask

    task automatic t_byte;
        mem[10'h100] = 8'h3C; mem[10'h201] = 8'hEE;
        prog(0, 20'h00100, 20'h00200, 20'd50, EN | SINC | DINC, 20'h0);
        sreq(0); wait_cyc(10);
        chk("R2 byte copied", 32'(mem[10'h200]), 32'h3C);
        chk("R2 upper byte untouched", 32'(mem[10'h201]), 32'hEE);
    endtask

    task automatic t_word;
        mem[10'h110] = 8'h12; mem[10'h111] = 8'h34; mem[10'h212] = 8'hEE;
        prog(1, 20'h00110, 20'h00210, 20'd50, EN | WORD | SINC | DINC, 20'h0);
        sreq(1); wait_cyc(10);
        chk("R3 word low", 32'(mem[10'h210]), 32'h12);
        chk("R3 word high", 32'(mem[10'h211]), 32'h34);
        chk("R3 next byte untouched", 32'(mem[10'h212]), 32'hEE);
    endtask

    task automatic t_inc;
        mem[10'h130] = 8'hA1; mem[10'h131] = 8'hA2; mem[10'h221] = 8'hEE;
        prog(0, 20'h00130, 20'h00220, 20'd50, EN | SINC, 20'h0);
        sreq(0); wait_cyc(10); sreq(0); wait_cyc(10);
        chk("R6 fixed dst gets 2nd src byte", 32'(mem[10'h220]), 32'hA2);
        chk("R6 fixed dst neighbour", 32'(mem[10'h221]), 32'hEE);
        for (int i = 0; i < 4; i++) mem[10'h140 + i] = 8'(8'hB0 + i);
        prog(0, 20'h00140, 20'h00230, 20'd50, EN | WORD | SINC | DINC, 20'h0);
        sreq(0); wait_cyc(10); sreq(0); wait_cyc(10);
        chk("R6 word step 2 low", 32'(mem[10'h232]), 32'hB2);
        chk("R6 word step 2 high", 32'(mem[10'h233]), 32'hB3);
    endtask

    task automatic t_irq;
        int w0;
        prog(0, 20'h00150, 20'h00250, 20'd50, EN | SINC | DINC, 20'h3);
        w0 = nwr;
        @(negedge clk); irq_in[5] = 1'b1; @(negedge clk); irq_in[5] = 1'b0;
        wait_cyc(10);
        chk("R5 unselected line ignored", 32'(nwr - w0), 0);
        irq_in[3] = 1'b1; wait_cyc(12); irq_in[3] = 1'b0; wait_cyc(4);
        chk("R5 held line gives one transfer", 32'(nwr - w0), 1);
        chk("R5 data", 32'(mem[10'h250]), 32'(mem[10'h150]));
    endtask

    task automatic t_single;
        int w0, d0;
        mem[10'h161] = 8'h77;
        prog(0, 20'h00160, 20'h00260, 20'd2, EN | SINC | DINC, 20'h0);
        d0 = done_cnt[0];
        sreq(0); wait_cyc(10);
        chk("R7 enabled before terminal", 32'(ch_en[0]), 1);
        sreq(0); wait_cyc(10);
        chk("R7 second byte", 32'(mem[10'h261]), 32'h77);
        chk("R7 enable cleared", 32'(ch_en[0]), 0);
        chk("R7 one done pulse", 32'(done_cnt[0] - d0), 1);
        w0 = nwr;
        sreq(0); wait_cyc(10);
        chk("R7 ignored after terminal", 32'(nwr - w0), 0);
    endtask

    task automatic t_repeat;
        int d0;
        mem[10'h180] = 8'h11; mem[10'h181] = 8'h22; mem[10'h282] = 8'hEE;
        prog(1, 20'h00180, 20'h00280, 20'd2, EN | SINC | DINC | RPT, 20'h0);
        d0 = done_cnt[1];
        sreq(1); wait_cyc(10); sreq(1); wait_cyc(10);
        chk("R8 second byte", 32'(mem[10'h281]), 32'h22);
        chk("R8 stays enabled", 32'(ch_en[1]), 1);
        chk("R8 done pulse", 32'(done_cnt[1] - d0), 1);
        mem[10'h180] = 8'h33;
        sreq(1); wait_cyc(10);
        chk("R8 pointers reloaded", 32'(mem[10'h280]), 32'h33);
        chk("R8 no write past reload", 32'(mem[10'h282]), 32'hEE);
    endtask

    task automatic t_merge;
        int w0, a0;
        prog(1, 20'h001A0, 20'h002A0, 20'd100, EN, 20'h0);
        w0 = nwr; a0 = nacc;
        gnt_block = 1'b1;
        sreq(1); wait_cyc(4);
        chk("R11 request held while waiting", 32'(bus_req), 1);
        chk("R11 no access without grant", 32'(nacc - a0), 0);
        sreq(1); sreq(1); sreq(1);
        gnt_block = 1'b0;
        wait_cyc(20);
        chk("R9 merged requests give two transfers", 32'(nwr - w0), 2);
    endtask

    task automatic t_disabled;
        int w0, q0;
        mem[10'h2C0] = 8'hEE;
        prog(1, 20'h001C0, 20'h002C0, 20'd10, 20'h0, 20'h0);
        w0 = nwr; q0 = nreq;
        sreq(1); wait_cyc(10);
        chk("R4 no bus request", 32'(nreq - q0), 0);
        chk("R4 no write", 32'(nwr - w0), 0);
        wr(1, 3'd3, EN); wait_cyc(10);
        chk("R4 request not remembered", 32'(nwr - w0), 0);
        chk("R4 dst unchanged", 32'(mem[10'h2C0]), 32'hEE);
    endtask

    task automatic t_prio;
        int a0;
        mem[10'h190] = 8'h5A; mem[10'h198] = 8'hA5;
        prog(0, 20'h00190, 20'h00290, 20'd10, EN, 20'h6);
        prog(1, 20'h00198, 20'h00298, 20'd10, EN, 20'h6);
        a0 = nacc;
        @(negedge clk); irq_in[6] = 1'b1; @(negedge clk); irq_in[6] = 1'b0;
        wait_cyc(16);
        chk("R10 four accesses", 32'(nacc - a0), 4);
        chk("R10 ch0 read first", 32'(alog[a0 % 64]), 32'h190);
        chk("R10 ch0 write second", 32'(alog[(a0 + 1) % 64]), 32'h290);
        chk("R10 ch1 read third", 32'(alog[(a0 + 2) % 64]), 32'h198);
        chk("R10 ch1 write last", 32'(alog[(a0 + 3) % 64]), 32'h298);
        chk("R10 data ch0", 32'(mem[10'h290]), 32'h5A);
        chk("R10 data ch1", 32'(mem[10'h298]), 32'hA5);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(2);
        t_byte();
        t_word();
        t_inc();
        t_irq();
        t_single();
        t_repeat();
        t_merge();
        t_disabled();
        t_prio();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule